// File: doc/BRIEF.md
# Daisy-chainable SPI command slave

This block is a serial-peripheral slave that turns 16-bit commands from a host into strobes for an attached register file. The host lowers chip select, clocks in a command most significant bit first and raises chip select again. On that rising edge the block decodes the last sixteen bits it sampled into a write strobe or a read strobe, each with a 5-bit register address. A write also carries 10 bits of data.

While the next command is clocked in, the serial output returns a confirmation word. This is either the previous command itself or, after a read, the address together with the register contents. The host can therefore check each command one frame later. Because the output shifts out whatever came in sixteen clocks earlier, several blocks can be chained with each output feeding the next input. A frame whose clock count is not a multiple of sixteen sets a sticky framing-fault flag and does nothing else. Commands of all zeros or all ones are discarded.

The serial pins are brought into a system clock running at least four times faster than the serial clock. Input data is sampled on the rising serial-clock edge and the output changes on the falling edge.

Top module: `spi_cmd_slave`

## Requirements
- R1: A command is 16 bits, sent MSB first. Bits [15:11] are the address, bit 10 is the direction and bits [9:0] are the data. With direction 1 (write), `reg_wr` pulses with `reg_addr` and `reg_wdata` taken from the command.
- R2: With direction 0 (read), `reg_rd` pulses with `reg_addr` taken from the command. `reg_rdata` is taken one clock after the `reg_rd` pulse.
- R3: After a valid write command or a discarded command, the next frame shifts out on `spi_miso` the 16-bit word that was received, MSB first.
- R4: After a read, the next frame shifts out {address, 0, register contents}, in the same field positions as the command.
- R5: A read of the write-only action address (parameter, default 30) returns zero in the data field.
- R6: The all-zero word 0x0000 and the all-one word 0xFFFF produce neither strobe.
- R7: A frame with a nonzero rising-edge count that is not a multiple of 16 sets `frame_fault` and produces no strobe. The flag stays set until reset.
- R8: A chip-select pulse with no serial clock edges produces no strobe and does not set `frame_fault`.
- R9: In a frame longer than 16 bits (a multiple of 16), only the last 16 bits form the command. Bits shifted in appear on `spi_miso` 16 clocks later, which lets blocks be chained.
- R10: After reset, `spi_miso`, `reg_wr`, `reg_rd` and `frame_fault` are 0, and the first frame shifts out 0x0000.
- R11: Each accepted command produces exactly one strobe, one system clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 10 | Register write data |
| reg_rdata | input | 10 | Register read data, one clock after `reg_rd` |
| frame_fault | output | 1 | Sticky framing fault |

## Verification
The bench sweeps every address with a write and then a read. This exposes a design that loses the field order or takes the read data in the wrong cycle, because the echoed word would then differ from the address and contents the bench predicts. It sends 15- and 17-bit frames: a counter that only compares against 16 would still write, or would miss the fault. It also sends a chip-select pulse with no clocks, which a careless design would flag as a fault. Both discarded words are sent, and a 32-bit chained frame checks that the first word passes through to the output while only the second one executes.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 10;
  localparam int CMD_W  = ADDR_W + 1 + DATA_W;
  localparam int CNT_W  = $clog2(CMD_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall,
  input  logic             cs_active,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             mosi,
  input  logic [CMD_W-1:0] resp,
  output logic [CMD_W-1:0] rx_word,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             any_edge,
  output logic             miso
);
  logic [CMD_W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word  <= '0;
      tx_sr    <= '0;
      bit_cnt  <= '0;
      any_edge <= 1'b0;
    end else if (cs_fall) begin
      tx_sr    <= resp;
      bit_cnt  <= '0;
      any_edge <= 1'b0;
    end else if (cs_active) begin
      if (sclk_rise) begin
        rx_word  <= {rx_word[CMD_W-2:0], mosi};
        bit_cnt  <= bit_cnt + 1'b1;
        any_edge <= 1'b1;
      end
      if (sclk_fall) tx_sr <= {tx_sr[CMD_W-2:0], rx_word[0]};
    end
  end

  assign miso = tx_sr[CMD_W-1];
endmodule

// File: rtl/spi_decoder.sv
module spi_decoder
  import spi_cmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ACT_ADDR = 5'd30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_rise,
  input  logic [CMD_W-1:0]  rx_word,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              any_edge,
  input  logic [DATA_W-1:0] rdata,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              fault,
  output logic [CMD_W-1:0]  resp
);
  cmd_t cmd;
  logic blank;
  logic rd_pend;

  assign cmd   = cmd_t'(rx_word);
  assign blank = (rx_word == '0) || (rx_word == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      rd_pend <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      fault   <= 1'b0;
      resp    <= '0;
    end else begin
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      rd_pend <= rd_stb;
      if (rd_pend)
        resp <= {addr, 1'b0, (addr == ACT_ADDR) ? {DATA_W{1'b0}} : rdata};
      if (cs_rise) begin
        addr  <= cmd.addr;
        wdata <= cmd.data;
        resp  <= rx_word;
        if (any_edge) begin
          if (bit_cnt != '0) fault <= 1'b1;
          else if (!blank) begin
            wr_stb <= cmd.wr;
            rd_stb <= !cmd.wr;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ACT_ADDR    = 5'd30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              frame_fault
);
  logic [2:0]       pins_s;
  logic             sclk_q, cs_q;
  logic             sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [CMD_W-1:0] rx_word, resp;
  logic [CNT_W-1:0] bit_cnt;
  logic             any_edge;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= pins_s[2];
      cs_q   <= pins_s[1];
    end
  end

  assign sclk_rise = pins_s[2] & ~sclk_q;
  assign sclk_fall = ~pins_s[2] & sclk_q;
  assign cs_fall   = ~pins_s[1] & cs_q;
  assign cs_rise   = pins_s[1] & ~cs_q;

  spi_shifter i_shift (
    .clk(clk), .rst(rst),
    .cs_fall(cs_fall), .cs_active(~pins_s[1]),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi(pins_s[0]), .resp(resp),
    .rx_word(rx_word), .bit_cnt(bit_cnt), .any_edge(any_edge),
    .miso(spi_miso)
  );

  spi_decoder #(.ACT_ADDR(ACT_ADDR)) i_dec (
    .clk(clk), .rst(rst),
    .cs_rise(cs_rise), .rx_word(rx_word), .bit_cnt(bit_cnt),
    .any_edge(any_edge), .rdata(reg_rdata),
    .wr_stb(reg_wr), .rd_stb(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .fault(frame_fault), .resp(resp)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [4:0] reg_addr,
  input logic [9:0] reg_wdata,
  input logic       frame_fault
);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  assert_wr_single_R11: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  assert_rd_single_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    frame_fault |=> frame_fault);

  assert_fault_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_fault) |-> !reg_wr && !reg_rd);

  assert_no_ones_write_R6: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !(reg_addr == 5'h1f && reg_wdata == 10'h3ff));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk i_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .frame_fault(frame_fault)
);

// File: tb/test_spi_cmd_slave.sv
module test_spi_cmd_slave;
  localparam int HALF = 8;
  localparam logic [4:0] ACT = 5'd30;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_wr, reg_rd, frame_fault;
  logic [4:0] reg_addr;
  logic [9:0] reg_wdata, reg_rdata;

  logic [9:0] mem [32];
  logic [9:0] expm [32];
  int wr_cnt = 0, rd_cnt = 0;
  int checks = 0, errors = 0;
  logic [15:0] prev;
  logic [63:0] cap;

  always #4 clk = ~clk;

  spi_cmd_slave i_spi_cmd_slave (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_fault(frame_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) mem[i] <= 10'((i * 13 + 7) & 10'h3ff);
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
      if (reg_rd) begin reg_rdata <= mem[reg_addr]; rd_cnt <= rd_cnt + 1; end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [63:0] data, output logic [63:0] got);
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) mosi = data[i];
      wclk(HALF);
      got = {got[62:0], miso};
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    cs_n = 1'b1;
    wclk(20);
  endtask

  initial begin
    int w0, r0;
    logic [15:0] w;
    for (int i = 0; i < 32; i++) expm[i] = 10'((i * 13 + 7) & 10'h3ff);
    wclk(5);
    chk("R10 miso", 64'(miso), 0);
    chk("R10 strobes", 64'({reg_wr, reg_rd}), 0);
    chk("R10 fault", 64'(frame_fault), 0);
    @(negedge clk) rst = 1'b0;
    wclk(5);
    prev = 16'h0000;
    // R1 write sweep, R3 echo of the previous command
    for (int a = 0; a < 32; a++) begin
      logic [9:0] f = 10'((a * 37 + 5) & 10'h3ff);
      w = {5'(a), 1'b1, f};
      w0 = wr_cnt;
      xfer(16, 64'(w), cap);
      chk("R3 echo", cap[15:0], prev);
      chk("R1 write", 64'(mem[a]), 64'(f));
      chk("R11 one strobe", 64'(wr_cnt - w0), 1);
      expm[a] = f;
      prev = w;
    end
    // R2 read sweep, R4/R5 response
    for (int a = 0; a < 32; a++) begin
      w = {5'(a), 1'b0, 10'h155};
      r0 = rd_cnt;
      xfer(16, 64'(w), cap);
      chk("R4 read echo", cap[15:0], prev);
      chk("R2 read strobe", 64'(rd_cnt - r0), 1);
      prev = {5'(a), 1'b0, (5'(a) == ACT) ? 10'h000 : expm[a]};
    end
    // R6 all zeros
    w0 = wr_cnt; r0 = rd_cnt;
    xfer(16, 64'h0000, cap);
    chk("R5/R4 last read echo", cap[15:0], prev);
    chk("R6 zeros no strobe", 64'((wr_cnt - w0) + (rd_cnt - r0)), 0);
    // R6 all ones
    xfer(16, 64'hffff, cap);
    chk("R3 echo of zero word", cap[15:0], 0);
    chk("R6 ones no strobe", 64'((wr_cnt - w0) + (rd_cnt - r0)), 0);
    chk("R6 ones reg31", 64'(mem[31]), 64'(expm[31]));
    // R9 chained 32-bit frame
    w0 = wr_cnt;
    xfer(32, {32'h0, 5'd3, 1'b1, 10'h2aa, 5'd9, 1'b1, 10'h0f0}, cap);
    chk("R3 echo of ones word", cap[31:16], 64'hffff);
    chk("R9 passthrough", cap[15:0], 64'({5'd3, 1'b1, 10'h2aa}));
    chk("R9 last word executes", 64'(mem[9]), 64'h0f0);
    chk("R9 first word ignored", 64'(mem[3]), 64'(expm[3]));
    chk("R9 one strobe", 64'(wr_cnt - w0), 1);
    expm[9] = 10'h0f0;
    // R8 empty chip-select pulse
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk) cs_n = 1'b0;
    wclk(20);
    cs_n = 1'b1;
    wclk(20);
    chk("R8 no fault", 64'(frame_fault), 0);
    chk("R8 no strobe", 64'((wr_cnt - w0) + (rd_cnt - r0)), 0);
    // R7 short and long frames
    xfer(15, 64'({5'd4, 1'b1, 10'h001}), cap);
    chk("R7 fault 15", 64'(frame_fault), 1);
    chk("R7 no write 15", 64'(wr_cnt - w0), 0);
    xfer(17, 64'({1'b0, 5'd5, 1'b1, 10'h011}), cap);
    chk("R7 no write 17", 64'(wr_cnt - w0), 0);
    chk("R7 reg5 kept", 64'(mem[5]), 64'(expm[5]));
    xfer(16, 64'({5'd6, 1'b1, 10'h066}), cap);
    chk("R1 write after fault", 64'(mem[6]), 64'h066);
    chk("R7 fault sticky", 64'(frame_fault), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule